// File: doc/BRIEF.md
# Clock Source and Clock-Pin Control Register

This block holds one write-only control byte that decides how the internal system clock is derived from the crystal clock and what drives a shared clock pin. The system clock is expressed as a clock-enable (`sys_clk_en_o`) in the crystal domain. That enable runs at the full crystal rate, at half the crystal rate, or follows an external programmable-divider enable. A separate select output tells downstream clock generation to use the inverted crystal edge.

The shared pin has a fixed priority order. An audio left/right clock wins whenever the audio mode field from a neighbouring register is nonzero. With the audio mode at zero, a sync-monitor bit routes the sync pulse to the pin. Below that, a clock-output enable drives a divided copy of the system clock. With none of these, the pin is released to its pull-up. A read at the register address returns a fixed version byte rather than the stored control value.

Top module: `clkpin_ctl`

## Requirements
- R1: After reset the control byte is zero: `pin_oe_o` is 0 and `sys_clk_en_o` is 1 on every crystal cycle.
- R2: With the audio mode at 0, bit 6 at 0 and bit 7 at 0, `pin_oe_o` is 0 and `pin_o` is 1, the level the pull-up gives.
- R3: With `aud_mode_i` nonzero, `pin_oe_o` is 1 and `pin_o` equals `lrck_i`, whatever bits 7 and 6 hold.
- R4: With the audio mode at 0, bit 6 at 0 and bit 7 at 1, `pin_oe_o` is 1 and `pin_o` carries the divided system clock.
- R5: Bits 3:2 select the divided clock. Code 0 toggles once per system tick (divide by 2). Code 1 toggles every second system tick (divide by 4). Code 2 is a registered copy of the system tick (divide by 1).
- R6: Code 3 in bits 3:2 holds the divided clock at 0.
- R7: A change of bits 3:2 clears the divider one cycle after the write lands. The new waveform therefore starts from a low phase, with no runt high pulse.
- R8: Bit 0 set makes `sys_clk_en_o` assert on alternate crystal cycles.
- R9: Bit 4 set makes `sys_clk_en_o` follow `prog_en_i`, and bit 4 overrides bit 0.
- R10: `sys_clk_inv_o` equals bit 5 of the control byte.
- R11: With the audio mode at 0 and bit 6 set, `pin_oe_o` is 1 and `pin_o` equals `sync_i`, even when bit 7 is also set.
- R12: A read at `REG_ADDR` returns `VERSION`, and a read elsewhere returns 0. A write to any other address leaves the control byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Crystal clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Read data |
| aud_mode_i | input | 2 | Audio output mode field from another register |
| lrck_i | input | 1 | Audio left/right clock |
| sync_i | input | 1 | Detected or inserted sync pulse |
| prog_en_i | input | 1 | Programmable-divider clock enable |
| sys_clk_en_o | output | 1 | System clock enable |
| sys_clk_inv_o | output | 1 | Use inverted crystal edge |
| pin_o | output | 1 | Shared pin output value |
| pin_oe_o | output | 1 | Shared pin output enable |

## Verification
The bench tests the pin priority by raising the audio mode, the sync-monitor bit and the clock enable together. A mux with the wrong order would show the divided clock where sync or the left/right clock belongs. It counts rising edges of the pin over fixed windows for each frequency code, with and without crystal halving. A divider that ignores halving or mis-decodes a code gives the wrong edge count. After a code change it samples the pin for the next three cycles. A divider that is not cleared would emit an early high phase. Reads at the register address are checked for the version byte, and writes to a wrong address are checked to leave the pin state unchanged.

// File: rtl/clkpin_pkg.sv
package clkpin_pkg;
  typedef enum logic [1:0] {
    FSEL_DIV2 = 2'd0,
    FSEL_DIV4 = 2'd1,
    FSEL_DIV1 = 2'd2,
    FSEL_RSVD = 2'd3
  } fsel_e;

  typedef struct packed {
    logic  clk_out_en;  // 7
    logic  sync_mon;    // 6
    logic  xtal_inv;    // 5
    logic  prog_sel;    // 4
    fsel_e fsel;        // 3:2
    logic  rsvd;        // 1
    logic  xtal_half;   // 0
  } ctl_t;
endpackage

// File: rtl/clkpin_sysgen.sv
module clkpin_sysgen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic half_i,
  input  logic prog_sel_i,
  input  logic prog_en_i,
  output logic sys_en_o
);
  logic half_ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      half_ph_q <= 1'b1;
    else if (!half_i) half_ph_q <= 1'b1;
    else              half_ph_q <= ~half_ph_q;
  end

  always_comb begin
    if (prog_sel_i)  sys_en_o = prog_en_i;
    else if (half_i) sys_en_o = half_ph_q;
    else             sys_en_o = 1'b1;
  end
endmodule

// File: rtl/clkpin_outdiv.sv
module clkpin_outdiv
  import clkpin_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sys_en_i,
  input  fsel_e            fsel_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             div_clk_o
);
  fsel_e            fsel_q;
  logic [CNT_W-1:0] cnt_q;
  logic             tick_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fsel_q <= FSEL_DIV2;
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= sys_en_i;
      if (fsel_i != fsel_q) begin
        // restart from low phase on code change
        fsel_q <= fsel_i;
        cnt_q  <= '0;
      end else if (sys_en_i) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  always_comb begin
    unique case (fsel_q)
      FSEL_DIV2: div_clk_o = cnt_q[0];
      FSEL_DIV4: div_clk_o = cnt_q[1];
      FSEL_DIV1: div_clk_o = tick_q;
      default:   div_clk_o = 1'b0;
    endcase
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/clkpin_mux.sv
module clkpin_mux (
  input  logic [1:0] aud_mode_i,
  input  logic       lrck_i,
  input  logic       sync_mon_i,
  input  logic       sync_i,
  input  logic       clk_out_en_i,
  input  logic       div_clk_i,
  output logic       pin_o,
  output logic       pin_oe_o
);
  always_comb begin
    pin_oe_o = 1'b1;
    if (aud_mode_i != 2'd0)  pin_o = lrck_i;
    else if (sync_mon_i)     pin_o = sync_i;
    else if (clk_out_en_i)   pin_o = div_clk_i;
    else begin
      pin_o    = 1'b1;  // pull-up level
      pin_oe_o = 1'b0;
    end
  end
endmodule

// File: rtl/clkpin_ctl.sv
module clkpin_ctl
  import clkpin_pkg::*;
#(
  parameter int              ADDR_W   = 8,
  parameter int              DATA_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h1A,
  parameter logic [DATA_W-1:0] VERSION  = 8'h43,
  parameter int              CNT_W    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [1:0]        aud_mode_i,
  input  logic              lrck_i,
  input  logic              sync_i,
  input  logic              prog_en_i,
  output logic              sys_clk_en_o,
  output logic              sys_clk_inv_o,
  output logic              pin_o,
  output logic              pin_oe_o
);
  localparam int CTL_W = $bits(ctl_t);

  ctl_t             ctl_q;
  logic             hit;
  logic [CNT_W-1:0] div_cnt;
  logic             div_clk;

  assign hit = (addr_i == REG_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         ctl_q <= '0;
    else if (we_i && hit) ctl_q <= ctl_t'(wdata_i[CTL_W-1:0]);
  end

  assign rdata_o       = (rd_en_i && hit) ? VERSION : '0;
  assign sys_clk_inv_o = ctl_q.xtal_inv;

  clkpin_sysgen u_sysgen (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .half_i     (ctl_q.xtal_half),
    .prog_sel_i (ctl_q.prog_sel),
    .prog_en_i  (prog_en_i),
    .sys_en_o   (sys_clk_en_o)
  );

  clkpin_outdiv #(.CNT_W(CNT_W)) u_outdiv (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sys_en_i  (sys_clk_en_o),
    .fsel_i    (ctl_q.fsel),
    .cnt_o     (div_cnt),
    .div_clk_o (div_clk)
  );

  clkpin_mux u_mux (
    .aud_mode_i   (aud_mode_i),
    .lrck_i       (lrck_i),
    .sync_mon_i   (ctl_q.sync_mon),
    .sync_i       (sync_i),
    .clk_out_en_i (ctl_q.clk_out_en),
    .div_clk_i    (div_clk),
    .pin_o        (pin_o),
    .pin_oe_o     (pin_oe_o)
  );
endmodule

// File: rtl/clkpin_ctl_chk.sv
module clkpin_ctl_chk #(
  parameter int                ADDR_W   = 8,
  parameter int                DATA_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h1A,
  parameter logic [DATA_W-1:0] VERSION  = 8'h43,
  parameter int                CNT_W    = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              rd_en_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [1:0]        aud_mode_i,
  input logic              lrck_i,
  input logic              sync_i,
  input logic              prog_en_i,
  input logic              sys_clk_en_o,
  input logic              pin_o,
  input logic              pin_oe_o,
  input logic [7:0]        ctl_bits,
  input logic [CNT_W-1:0]  div_cnt
);
  // R3
  audio_pin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aud_mode_i != 2'd0) |-> (pin_oe_o && pin_o == lrck_i));

  // R2
  pin_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aud_mode_i == 2'd0 && !ctl_bits[6] && !ctl_bits[7]) |-> (!pin_oe_o && pin_o));

  // R11
  sync_mon_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aud_mode_i == 2'd0 && ctl_bits[6]) |-> (pin_oe_o && pin_o == sync_i));

  // R9
  prog_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_bits[4] |-> (sys_clk_en_o == prog_en_i));

  // R7
  div_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_bits[3:2] != $past(ctl_bits[3:2])) |=> (div_cnt == '0));

  // R12
  version_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == REG_ADDR) |-> (rdata_o == VERSION));

  // R8
  half_alt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_bits[0] && !ctl_bits[4] && $past(ctl_bits[0]) && $past(sys_clk_en_o))
      |-> !sys_clk_en_o);
endmodule

bind clkpin_ctl clkpin_ctl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_ADDR(REG_ADDR),
  .VERSION(VERSION), .CNT_W(CNT_W)
) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .addr_i       (addr_i),
  .rd_en_i      (rd_en_i),
  .rdata_o      (rdata_o),
  .aud_mode_i   (aud_mode_i),
  .lrck_i       (lrck_i),
  .sync_i       (sync_i),
  .prog_en_i    (prog_en_i),
  .sys_clk_en_o (sys_clk_en_o),
  .pin_o        (pin_o),
  .pin_oe_o     (pin_oe_o),
  .ctl_bits     (ctl_q),
  .div_cnt      (div_cnt)
);

// File: tb/clkpin_ctl_tb_top.sv
`timescale 1ns/1ps
module clkpin_ctl_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic       we_i = 1'b0;
  logic       rd_en_i = 1'b0;
  logic [7:0] rdata_o;
  logic [1:0] aud_mode_i = '0;
  logic       lrck_i = 1'b0;
  logic       sync_i = 1'b0;
  logic       prog_en_i = 1'b0;
  logic       sys_clk_en_o, sys_clk_inv_o, pin_o, pin_oe_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  clkpin_ctl dut_i (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0; addr_i = '0;
  endtask

  task automatic count_rises(int cycles, output int rises);
    logic prev;
    rises = 0;
    prev = pin_o;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk_i);
      if (pin_o && !prev) rises++;
      prev = pin_o;
    end
  endtask

  task automatic t_reset;
    @(negedge clk_i);
    chk("R1 oe", pin_oe_o, 0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      chk("R1 sys_en", sys_clk_en_o, 1);
    end
    chk("R2 pullup level", pin_o, 1);
    chk("R10 inv clear", sys_clk_inv_o, 0);
  endtask

  task automatic t_freq;
    int r;
    wr(8'h1A, 8'h80);
    @(negedge clk_i);
    chk("R4 oe", pin_oe_o, 1);
    count_rises(64, r);
    chk("R5 div2 rises", (r >= 31 && r <= 33), 1);
    wr(8'h1A, 8'h84);
    @(negedge clk_i);
    count_rises(64, r);
    chk("R5 div4 rises", (r >= 15 && r <= 17), 1);
    wr(8'h1A, 8'h88);
    @(negedge clk_i);
    count_rises(16, r);
    chk("R5 div1 full-rate level", {pin_o, r[7:0]}, {1'b1, 8'd0});
    wr(8'h1A, 8'h89);
    @(negedge clk_i);
    count_rises(64, r);
    chk("R5 R8 div1 half rises", (r >= 31 && r <= 33), 1);
    wr(8'h1A, 8'h81);
    @(negedge clk_i);
    count_rises(64, r);
    chk("R8 div2 half rises", (r >= 15 && r <= 17), 1);
    wr(8'h1A, 8'h8C);
    @(negedge clk_i);
    count_rises(32, r);
    chk("R6 rsvd no edges", r, 0);
    chk("R6 rsvd low", pin_o, 0);
  endtask

  task automatic t_restart;
    wr(8'h1A, 8'h80);
    repeat (5) @(negedge clk_i);
    wr(8'h1A, 8'h84);
    @(negedge clk_i);
    chk("R7 low 1", pin_o, 0);
    @(negedge clk_i);
    chk("R7 low 2", pin_o, 0);
    @(negedge clk_i);
    chk("R7 first high", pin_o, 1);
  endtask

  task automatic t_sysclk;
    int ones;
    wr(8'h1A, 8'h01);
    ones = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk_i);
      if (sys_clk_en_o) ones++;
    end
    chk("R8 half ones", ones, 4);
    wr(8'h1A, 8'h11);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk_i);
      prog_en_i = (i % 3 == 0);
      #0.5;
      chk("R9 prog follow", sys_clk_en_o, prog_en_i);
    end
    prog_en_i = 1'b0;
    wr(8'h1A, 8'h20);
    @(negedge clk_i);
    chk("R10 inv set", sys_clk_inv_o, 1);
  endtask

  task automatic t_priority;
    wr(8'h1A, 8'hC0);
    sync_i = 1'b1;
    #0.5;
    chk("R11 sync high", {pin_oe_o, pin_o}, 2'b11);
    sync_i = 1'b0;
    #0.5;
    chk("R11 sync over clk", {pin_oe_o, pin_o}, 2'b10);
    @(negedge clk_i);
    chk("R11 sync held", pin_o, 0);
    aud_mode_i = 2'd2;
    lrck_i = 1'b1;
    #0.5;
    chk("R3 lrck over sync", {pin_oe_o, pin_o}, 2'b11);
    wr(8'h1A, 8'h00);
    lrck_i = 1'b0;
    #0.5;
    chk("R3 lrck with enable clear", {pin_oe_o, pin_o}, 2'b10);
    aud_mode_i = 2'd0;
    #0.5;
    chk("R2 released", {pin_oe_o, pin_o}, 2'b01);
  endtask

  task automatic t_regif;
    @(negedge clk_i);
    addr_i = 8'h1A; rd_en_i = 1'b1;
    #0.5;
    chk("R12 version", rdata_o, 8'h43);
    addr_i = 8'h1B;
    #0.5;
    chk("R12 other addr read", rdata_o, 8'h00);
    rd_en_i = 1'b0;
    wr(8'h1B, 8'h80);
    @(negedge clk_i);
    chk("R12 wrong addr write ignored", pin_oe_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_freq();
    t_restart();
    t_sysclk();
    t_priority();
    t_regif();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule